// File: doc/BRIEF.md
# Multi-Mode Timer Channel with Capture

This block is a single timer channel built around one up-counter that is shared by four functions. It can count to a programmed target, produce a two-phase PWM waveform, measure the width of a pulse on a capture input, or measure both the period and the active time of a repeating capture waveform. Plain configuration pins select the function, which input edge is active, single-shot or repeating operation, and the counting clock. The counting clock is either the core clock or the selected edge of an external clock input. In counter mode, a two-bit action field chooses what the output pin does when the target is reached.

Every completed count, PWM level change or capture is an event. An event sets a raw interrupt flag when interrupts are enabled. A mask gates the flag onto the interrupt output. A one-cycle read strobe on the current-value path clears the flag. An event that lands while the flag is still pending sets a sticky overflow flag. Results leave the block on plain status pins that are held until the next result. There is no streaming payload, so no valid/ready pair is used. Dropping the enable resets the counter and the mode state and leaves the configuration and the last captured values untouched.

Top module: `tmr_multi`

## Requirements
- R1: After reset, cur_val, cap_width, cap_period, int_raw, int_out and ovf are all 0.
- R2: In counter mode (mode=0) with the internal clock, the first event occurs target+1 cycles after enable and the counter returns to 0. With loop_en=1 the count repeats every target+1 cycles. With loop_en=0 the counter halts at 0 and raises no further events until enable is dropped.
- R3: While en=0, timer_out follows init_level one cycle later. At each counter-mode completion, out_act selects the pin action: 0 holds the level, 1 toggles it, 2 drives it high, 3 drives it low.
- R4: In PWM mode (mode=1), phase 0 lasts target[15:0] cycles at level init_level and phase 1 lasts target[31:16] cycles at the opposite level. A length of 0 is treated as 1. The phase output is 1 during phase 1. The waveform repeats regardless of loop_en.
- R5: In PWM mode, every output level change is an event.
- R6: In pulse-capture mode (mode=2), cap_width receives the number of core-clock cycles the capture input spent at its active level. The active level is high when edge_sel=0 and low when edge_sel=1. An event is raised when the inactive edge ends the pulse.
- R7: In duty-capture mode (mode=3), the first active edge only arms the measurement. Each later active edge loads cap_period with the cycles since the previous active edge and cap_width with the active time inside that period, and raises an event.
- R8: With loop_en=0, either capture mode records only one result per enable. Later edges do not change the capture outputs and raise no event.
- R9: An event sets int_raw only when int_en=1. int_out is int_raw gated by int_mask=0. A one-cycle rd_cur pulse clears int_raw and ovf, unless an event lands in the same cycle, in which case int_raw is set and ovf is cleared.
- R10: An event that arrives while int_raw is set and rd_cur is low sets ovf. ovf stays set until rd_cur.
- R11: With clk_src=1, the counter advances once per rising edge of ext_clk when edge_sel=0, or once per falling edge when edge_sel=1.
- R12: Clearing en returns cur_val to 0 within one cycle. It changes neither the configuration nor cap_width or cap_period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable; low resets counter and mode state |
| mode | input | 2 | 0 counter, 1 PWM, 2 pulse capture, 3 duty capture |
| edge_sel | input | 1 | 0 rising edge / high active, 1 falling edge / low active |
| loop_en | input | 1 | 1 repeat, 0 single shot |
| clk_src | input | 1 | 0 core clock, 1 external clock edges (counter and PWM) |
| out_act | input | 2 | Pin action at counter completion |
| init_level | input | 1 | Starting pin level and phase-0 level |
| target | input | 32 | Counter target, or PWM phase lengths |
| int_en | input | 1 | Allows events to set the raw flag |
| int_mask | input | 1 | 1 blocks int_out |
| ext_clk | input | 1 | External counting clock (asynchronous) |
| cap_in | input | 1 | Capture input (asynchronous) |
| rd_cur | input | 1 | Read strobe of the current value; clears int_raw and ovf |
| cur_val | output | 32 | Current counter value |
| cap_width | output | 32 | Captured active width |
| cap_period | output | 32 | Captured period (duty capture) |
| timer_out | output | 1 | Output pin level |
| phase | output | 1 | Active PWM phase |
| int_raw | output | 1 | Raw interrupt flag |
| int_out | output | 1 | Masked interrupt |
| ovf | output | 1 | Sticky interrupt overflow |

## Verification
The hardest condition to reach from the ports is a single-shot duty capture that must ignore a second, different waveform period. This only shows up if several active edges pass through the synchronizers while the flags are left unread. The stimulus therefore drives a capture waveform with two unequal periods and a closing edge. It runs that waveform once in single-shot mode, where the first result must survive and ovf must stay clear. It then runs the same waveform in loop mode, where the second result must replace the first and ovf must set. PWM phase lengths, including a zero-length phase, are measured from the pin in steady state rather than from the enable edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_COUNT = 2'd0,
    MODE_PWM   = 2'd1,
    MODE_PULSE = 2'd2,
    MODE_DUTY  = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_LOW    = 2'd3
  } tmr_act_e;

  function automatic logic apply_act(tmr_act_e act, logic cur);
    case (act)
      ACT_TOGGLE: apply_act = ~cur;
      ACT_HIGH:   apply_act = 1'b1;
      ACT_LOW:    apply_act = 1'b0;
      default:    apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic chain [STAGES];
  logic prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic int_en,
  input  logic int_mask,
  input  logic rd_clr,
  output logic raw,
  output logic ovf,
  output logic irq
);
  logic set_raw;
  assign set_raw = evt & int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= 1'b0;
      ovf <= 1'b0;
    end else if (rd_clr) begin
      raw <= set_raw;
      ovf <= 1'b0;
    end else if (set_raw) begin
      raw <= 1'b1;
      if (raw) ovf <= 1'b1;
    end
  end

  assign irq = raw & ~int_mask;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  tmr_mode_e        mode,
  input  logic             loop_en,
  input  tmr_act_e         out_act,
  input  logic             init_level,
  input  logic [CNT_W-1:0] target,
  input  logic             tick,
  input  logic             act_edge,
  input  logic             inact_edge,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_w,
  output logic [CNT_W-1:0] cap_p,
  output logic             pin,
  output logic             phase,
  output logic             evt
);
  localparam int HALF_W = CNT_W / 2;

  logic             halted, armed, measuring;
  logic [CNT_W-1:0] hold;
  logic [HALF_W-1:0] len_sel, len_eff;
  logic             hit_tgt, last_pwm;

  always_comb begin
    len_sel  = phase ? target[CNT_W-1:HALF_W] : target[HALF_W-1:0];
    len_eff  = (len_sel == '0) ? HALF_W'(1) : len_sel;
    last_pwm = (cnt == (CNT_W'(len_eff) - CNT_W'(1)));
    hit_tgt  = (cnt == target);
    case (mode)
      MODE_COUNT: evt = !halted && tick && hit_tgt;
      MODE_PWM:   evt = tick && last_pwm;
      MODE_PULSE: evt = !halted && measuring && inact_edge;
      default:    evt = !halted && armed && act_edge;
    endcase
    evt = evt && en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cap_w <= '0; cap_p <= '0; hold <= '0;
      pin <= 1'b0; phase <= 1'b0;
      halted <= 1'b0; armed <= 1'b0; measuring <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      phase <= 1'b0;
      halted <= 1'b0;
      armed <= 1'b0;
      measuring <= 1'b0;
      pin <= init_level;
    end else begin
      case (mode)
        MODE_COUNT: begin
          if (tick && !halted) begin
            if (hit_tgt) begin
              cnt    <= '0;
              pin    <= apply_act(out_act, pin);
              halted <= !loop_en;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        MODE_PWM: begin
          if (tick) begin
            if (last_pwm) begin
              cnt   <= '0;
              phase <= ~phase;
              pin   <= ~pin;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        MODE_PULSE: begin
          if (!halted) begin
            if (measuring && inact_edge) begin
              cap_w     <= cnt;
              cnt       <= '0;
              measuring <= 1'b0;
              halted    <= !loop_en;
            end else if (act_edge) begin
              cnt       <= CNT_W'(1);
              measuring <= 1'b1;
            end else if (measuring) begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (!halted) begin
            if (act_edge) begin
              cnt <= CNT_W'(1);
              if (armed) begin
                cap_p <= cnt;
                cap_w <= hold;
                if (!loop_en) begin
                  halted <= 1'b1;
                  armed  <= 1'b0;
                  cnt    <= '0;
                end
              end else begin
                armed <= 1'b1;
              end
            end else if (armed) begin
              if (inact_edge) hold <= cnt;
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_multi.sv
module tmr_multi
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             edge_sel,
  input  logic             loop_en,
  input  logic             clk_src,
  input  logic [1:0]       out_act,
  input  logic             init_level,
  input  logic [CNT_W-1:0] target,
  input  logic             int_en,
  input  logic             int_mask,
  input  logic             ext_clk,
  input  logic             cap_in,
  input  logic             rd_cur,
  output logic [CNT_W-1:0] cur_val,
  output logic [CNT_W-1:0] cap_width,
  output logic [CNT_W-1:0] cap_period,
  output logic             timer_out,
  output logic             phase,
  output logic             int_raw,
  output logic             int_out,
  output logic             ovf
);
  logic ext_rise, ext_fall, cap_rise, cap_fall;
  logic tick, act_edge, inact_edge, evt;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
  );

  assign tick       = clk_src ? (edge_sel ? ext_fall : ext_rise) : 1'b1;
  assign act_edge   = edge_sel ? cap_fall : cap_rise;
  assign inact_edge = edge_sel ? cap_rise : cap_fall;

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en),
    .mode(tmr_mode_e'(mode)), .loop_en(loop_en),
    .out_act(tmr_act_e'(out_act)), .init_level(init_level),
    .target(target), .tick(tick),
    .act_edge(act_edge), .inact_edge(inact_edge),
    .cnt(cur_val), .cap_w(cap_width), .cap_p(cap_period),
    .pin(timer_out), .phase(phase), .evt(evt)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .int_en(int_en),
    .int_mask(int_mask), .rd_clr(rd_cur),
    .raw(int_raw), .ovf(ovf), .irq(int_out)
  );
endmodule

// File: rtl/tmr_multi_chk.sv
module tmr_multi_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic             init_level,
  input logic             int_en,
  input logic             rd_cur,
  input logic [CNT_W-1:0] cur_val,
  input logic             timer_out,
  input logic             phase,
  input logic             int_raw,
  input logic             ovf
);
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cur_val == '0);

  p_idle_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> timer_out == $past(init_level));

  p_ovf_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(int_raw) && !$past(rd_cur)));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cur |=> !ovf);

  p_raw_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_raw) |-> $past(int_en));

  p_pwm_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'd1 && int_en && !rd_cur) ##1 (en && mode == 2'd1 && !$stable(phase))
      |-> int_raw);
endmodule

bind tmr_multi tmr_multi_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tmr_multi.sv
module tb_tmr_multi;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        edge_sel = 1'b0;
  logic        loop_en = 1'b0;
  logic        clk_src = 1'b0;
  logic [1:0]  out_act = 2'd0;
  logic        init_level = 1'b0;
  logic [31:0] target = 32'd0;
  logic        int_en = 1'b1;
  logic        int_mask = 1'b0;
  logic        ext_clk = 1'b0;
  logic        cap_in = 1'b0;
  logic        rd_cur = 1'b0;
  logic [31:0] cur_val, cap_width, cap_period;
  logic        timer_out, phase, int_raw, int_out, ovf;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  tmr_multi dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .edge_sel(edge_sel),
    .loop_en(loop_en), .clk_src(clk_src), .out_act(out_act),
    .init_level(init_level), .target(target), .int_en(int_en),
    .int_mask(int_mask), .ext_clk(ext_clk), .cap_in(cap_in), .rd_cur(rd_cur),
    .cur_val(cur_val), .cap_width(cap_width), .cap_period(cap_period),
    .timer_out(timer_out), .phase(phase), .int_raw(int_raw),
    .int_out(int_out), .ovf(ovf)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse();
    rd_cur = 1'b1;
    @(negedge clk);
    rd_cur = 1'b0;
  endtask

  task automatic wave(int hi, int lo);
    cap_in = 1'b1; cyc(hi);
    cap_in = 1'b0; cyc(lo);
  endtask

  task automatic run_len(logic lvl, output int n);
    n = 0;
    while (timer_out == lvl && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    cyc(1);
    chk("R1", "cur_val", cur_val, 0);
    chk("R1", "cap_width", cap_width, 0);
    chk("R1", "cap_period", cap_period, 0);
    chk("R1", "int_raw", int_raw, 0);
    chk("R1", "int_out", int_out, 0);
    chk("R1", "ovf", ovf, 0);
  endtask

  task automatic t_counter_single();
    int n;
    en = 0; mode = 2'd0; target = 32'd5; loop_en = 0; out_act = 2'd1; init_level = 0;
    cyc(2);
    en = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!int_raw && n < 50);
    chk("R2", "cycles to event", n, 6);
    chk("R3", "toggle action pin", timer_out, 1);
    cyc(20);
    chk("R2", "single halted value", cur_val, 0);
    chk("R2", "no second event", ovf, 0);
    rd_pulse();
    chk("R9", "raw after read", int_raw, 0);
  endtask

  task automatic t_out_actions();
    for (int a = 0; a < 4; a++) begin
      en = 0; init_level = (a == 2) ? 1'b0 : 1'b1; out_act = a[1:0]; target = 32'd2;
      cyc(2);
      chk("R3", "idle pin follows init", timer_out, init_level);
      en = 1;
      cyc(5);
      chk("R3", "action result", timer_out, (a == 0 || a == 2) ? 1 : 0);
      rd_pulse();
    end
  endtask

  task automatic t_loop_ovf();
    en = 0; target = 32'd3; loop_en = 1; out_act = 2'd0;
    cyc(2); rd_pulse();
    en = 1;
    cyc(4);
    chk("R2", "loop first event", int_raw, 1);
    chk("R10", "no ovf yet", ovf, 0);
    int_mask = 1; cyc(1);
    chk("R9", "masked int_out", int_out, 0);
    int_mask = 0; cyc(1);
    chk("R9", "unmasked int_out", int_out, 1);
    cyc(2);
    chk("R10", "ovf after second event", ovf, 1);
    rd_pulse();
    chk("R9", "raw cleared", int_raw, 0);
    chk("R9", "ovf cleared", ovf, 0);
    int_en = 0;
    cyc(10);
    chk("R9", "raw blocked by int_en", int_raw, 0);
    int_en = 1;
    en = 0; cyc(1);
  endtask

  task automatic t_pwm();
    int n;
    en = 0; mode = 2'd1; init_level = 1; target = {16'd3, 16'd5}; loop_en = 0;
    cyc(2); rd_pulse();
    en = 1;
    cyc(20);
    run_len(1'b1, n);
    run_len(1'b0, n);
    run_len(1'b1, n);
    chk("R4", "phase0 length", n, 5);
    chk("R4", "phase flag in phase1", phase, 1);
    run_len(1'b0, n);
    chk("R4", "phase1 length", n, 3);
    rd_pulse();
    chk("R5", "raw cleared in phase0", int_raw, 0);
    run_len(1'b1, n);
    chk("R5", "event at level change", int_raw, 1);
    en = 0; target = {16'd2, 16'd0};
    cyc(2);
    en = 1;
    cyc(10);
    run_len(1'b1, n);
    run_len(1'b0, n);
    run_len(1'b1, n);
    chk("R4", "zero length phase", n, 1);
    en = 0; cyc(1); rd_pulse();
  endtask

  task automatic t_pulse();
    en = 0; mode = 2'd2; edge_sel = 0; loop_en = 1; clk_src = 0; cap_in = 0;
    cyc(4); rd_pulse();
    en = 1; cyc(3);
    wave(7, 6);
    chk("R6", "high pulse width", cap_width, 7);
    chk("R6", "capture event", int_raw, 1);
    en = 0; edge_sel = 1; cap_in = 1;
    cyc(5); rd_pulse();
    en = 1; cyc(3);
    cap_in = 0; cyc(4);
    cap_in = 1; cyc(6);
    chk("R6", "low pulse width", cap_width, 4);
    en = 0; edge_sel = 0; cap_in = 0; cyc(4);
  endtask

  task automatic t_duty();
    en = 0; mode = 2'd3; edge_sel = 0; loop_en = 0; cap_in = 0;
    cyc(4); rd_pulse();
    en = 1; cyc(3);
    wave(2, 4); wave(5, 5); wave(1, 6);
    chk("R7", "single width", cap_width, 2);
    chk("R7", "single period", cap_period, 6);
    chk("R8", "single raised one event", int_raw, 1);
    chk("R8", "single no overflow", ovf, 0);
    en = 0; loop_en = 1;
    cyc(2); rd_pulse();
    en = 1; cyc(3);
    wave(2, 4); wave(5, 5); wave(1, 6);
    chk("R7", "loop width", cap_width, 5);
    chk("R7", "loop period", cap_period, 10);
    chk("R10", "two unread captures", ovf, 1);
    en = 0; cyc(1); rd_pulse();
  endtask

  task automatic t_ext_clk();
    en = 0; mode = 2'd0; clk_src = 1; edge_sel = 0; target = 32'd100; loop_en = 1; ext_clk = 0;
    cyc(4);
    en = 1; cyc(2);
    repeat (5) begin ext_clk = 1; cyc(3); ext_clk = 0; cyc(3); end
    cyc(4);
    chk("R11", "rising edge count", cur_val, 5);
    en = 0; cyc(1);
    chk("R12", "disable zeroes counter", cur_val, 0);
    edge_sel = 1; cyc(1);
    en = 1; cyc(2);
    repeat (3) begin ext_clk = 1; cyc(3); ext_clk = 0; cyc(3); end
    cyc(4);
    chk("R11", "falling edge count", cur_val, 3);
    en = 0; edge_sel = 0; clk_src = 0; cyc(1);
  endtask

  task automatic t_disable();
    target = 32'd1000; loop_en = 1;
    en = 1; cyc(10);
    chk("R12", "running value", cur_val, 10);
    en = 0; cyc(1);
    chk("R12", "stopped value", cur_val, 0);
    chk("R12", "width retained", cap_width, 5);
    chk("R12", "period retained", cap_period, 10);
    en = 1; cyc(4);
    chk("R12", "restart from zero", cur_val, 4);
    en = 0; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_counter_single();
    t_out_actions();
    t_loop_ovf();
    t_pwm();
    t_pulse();
    t_duty();
    t_ext_clk();
    t_disable();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule